// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash memory. It decides whether an embedded program or erase operation has finished. It does not read a status register. Instead it watches a status bit that the device inverts on every read while the operation is busy. After a start request the block latches the polling address, which must be a valid location inside the bank being operated on. It then issues status reads over a simple handshake: it raises a read request and holds it until the read-done strobe returns the data.

The reads are grouped in pairs. If the toggle bit holds its value across a pair, the operation is complete and the block reports pass. If the bit changed, the block looks at the timeout flag in the later read. With the flag clear, it starts another pair. With the flag set, it takes exactly one more pair, because the toggle bit may stop at the same moment the timeout flag rises. That last pair decides between pass and fail. An iteration limit ends polling with fail if the device never settles. The result is a one-cycle done pulse with exactly one of pass or fail.

Top module: `toggle_poll_top`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_req_o, done_o, pass_o and fail_o are low and rd_addr_o is zero.
- R2: A start_i seen in idle latches poll_addr_i. In the next cycle rd_req_o rises with rd_addr_o equal to the latched address, and rd_addr_o stays constant until polling ends.
- R3: rd_req_o stays high from the accepted start until the cycle after the rd_done_i that ends polling, and low whenever the block is idle.
- R4: Reads are paired. If bit 6 of the two reads' data is equal, the cycle after the second rd_done_i shows done_o with pass_o.
- R5: If bit 6 differs within a pair and bit 5 of the later read is 0, another pair is started. Bit 5 of the earlier read has no effect.
- R6: If bit 6 differs and bit 5 of the later read is 1, one more pair is read. If bit 6 is equal in that pair, the result is pass.
- R7: If bit 6 differs in that extra pair, the result is fail, whatever bit 5 shows.
- R8: done_o is high for one cycle only, with exactly one of pass_o and fail_o. Both are low when done_o is low.
- R9: A start_i received while polling is ignored. The address and the read sequence are unchanged.
- R10: With MAX_PAIRS nonzero (default 8), the MAX_PAIRS-th consecutive pair that toggles with bit 5 clear ends polling with fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin polling |
| poll_addr_i | input | ADDR_W | Address to poll, inside the bank under operation |
| rd_data_i | input | DATA_W | Status read data, valid with rd_done_i |
| rd_done_i | input | 1 | Read completion strobe |
| rd_req_o | output | 1 | Read request, held until rd_done_i |
| rd_addr_o | output | ADDR_W | Address of the status reads |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed |
| fail_o | output | 1 | Operation timed out or never settled |

## Verification
The bench sends the case where the toggle bit still changes after the timeout flag rises. A design that fails at once on the flag would report fail for a device that actually finished. It also sends the case where the extra pair keeps toggling with the flag clear again. A design that reopens normal polling there would hang or pass wrongly. Other stimulus sets the timeout flag only in the earlier read, sends a second start in the middle of polling with a different address, and runs the iteration limit to exhaustion. These catch a design that reads the flag from the wrong read, restarts or re-latches on a busy start, or counts pairs off by one. Read latency varies from zero to several cycles, and the outputs are compared every cycle against a behavioural model.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_A = 2'd1,
        ST_RD_B = 2'd2
    } tp_state_e;

    typedef enum logic [1:0] {
        ACT_NEXT  = 2'd0,
        ACT_RECHK = 2'd1,
        ACT_PASS  = 2'd2,
        ACT_FAIL  = 2'd3
    } tp_action_e;

    typedef struct packed {
        logic settled;
        logic timeout;
    } tp_verdict_t;

    function automatic tp_action_e tp_decide(input tp_verdict_t v,
                                             input logic recheck,
                                             input logic limit_hit);
        if (v.settled)
            return ACT_PASS;
        else if (recheck)
            return ACT_FAIL;
        else if (v.timeout)
            return ACT_RECHK;
        else if (limit_hit)
            return ACT_FAIL;
        return ACT_NEXT;
    endfunction

endpackage

// File: rtl/tp_sampler.sv
module tp_sampler
    import tp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int TOG_BIT = 6,
    parameter int TO_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] rd_data,
    output tp_verdict_t       verdict
);
    logic first_tog;

    always_ff @(posedge clk) begin
        if (rst)
            first_tog <= 1'b0;
        else if (cap_en)
            first_tog <= rd_data[TOG_BIT];
    end

    always_comb begin
        verdict.settled = (first_tog == rd_data[TOG_BIT]);
        verdict.timeout = rd_data[TO_BIT];
    end
endmodule

// File: rtl/tp_limit.sv
module tp_limit #(
    parameter int MAX_PAIRS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CNT_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

    generate
        if (MAX_PAIRS == 0) begin : g_off
            assign hit = 1'b0;
        end else begin : g_on
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    cnt <= '0;
                else if (inc)
                    cnt <= cnt + 1'b1;
            end
            assign hit = (cnt == CNT_W'(MAX_PAIRS - 1));
        end
    endgenerate
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
    import tp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic              rd_done_i,
    input  tp_verdict_t       verdict,
    input  logic              limit_hit,
    output logic              cap_en,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);
    tp_state_e         state;
    logic              recheck;
    logic [ADDR_W-1:0] addr_q;
    tp_action_e        act;
    logic              pair_end;

    assign pair_end = (state == ST_RD_B) && rd_done_i;
    assign act      = tp_decide(verdict, recheck, limit_hit);
    assign cap_en   = (state == ST_RD_A) && rd_done_i;
    assign cnt_clr  = (state == ST_IDLE) && start_i;
    assign cnt_inc  = pair_end && (act == ACT_NEXT);
    assign rd_req_o = (state != ST_IDLE);
    assign rd_addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            recheck <= 1'b0;
            addr_q  <= '0;
            done_o  <= 1'b0;
            pass_o  <= 1'b0;
            fail_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= poll_addr_i;
                        recheck <= 1'b0;
                        state   <= ST_RD_A;
                    end
                end
                ST_RD_A: begin
                    if (rd_done_i)
                        state <= ST_RD_B;
                end
                ST_RD_B: begin
                    if (rd_done_i) begin
                        unique case (act)
                            ACT_NEXT:  state <= ST_RD_A;
                            ACT_RECHK: begin
                                recheck <= 1'b1;
                                state   <= ST_RD_A;
                            end
                            ACT_PASS: begin
                                done_o <= 1'b1;
                                pass_o <= 1'b1;
                                state  <= ST_IDLE;
                            end
                            ACT_FAIL: begin
                                done_o <= 1'b1;
                                fail_o <= 1'b1;
                                state  <= ST_IDLE;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/toggle_poll_top.sv
module toggle_poll_top
    import tp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int TOG_BIT   = 6,
    parameter int TO_BIT    = 5,
    parameter int MAX_PAIRS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_done_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);
    tp_verdict_t verdict;
    logic        cap_en, cnt_clr, cnt_inc, limit_hit;

    tp_sampler #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .TO_BIT(TO_BIT)) u_sampler (
        .clk(clk), .rst(rst), .cap_en(cap_en), .rd_data(rd_data_i), .verdict(verdict)
    );

    tp_limit #(.MAX_PAIRS(MAX_PAIRS)) u_limit (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .hit(limit_hit)
    );

    tp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .poll_addr_i(poll_addr_i),
        .rd_done_i(rd_done_i), .verdict(verdict), .limit_hit(limit_hit),
        .cap_en(cap_en), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o)
    );
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_done_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o
);
    // R8
    result_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({pass_o, fail_o}) == 1));

    // R8
    result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (!pass_o && !fail_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_done_i) |=> rd_req_o);

    // R3
    req_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_req_o);
endmodule

bind toggle_poll_top tp_chk #(.ADDR_W(ADDR_W)) u_tp_chk (
    .clk(clk), .rst(rst), .rd_done_i(rd_done_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/tb_toggle_poll_top.sv
module tb_toggle_poll_top;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [AW-1:0] poll_addr_i = '0;
    logic [DW-1:0] rd_data_i = '0;
    logic rd_done_i = 1'b0;
    logic rd_req_o, done_o, pass_o, fail_o;
    logic [AW-1:0] rd_addr_o;

    always #10 clk = ~clk;

    toggle_poll_top #(.ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(MAXP)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .poll_addr_i(poll_addr_i),
        .rd_data_i(rd_data_i), .rd_done_i(rd_done_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
    );

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] rq[$];
    int lat = 0;
    int lat_cnt = 0;

    // behavioural reference state
    bit m_busy = 0, m_first = 1, m_rc = 0, m_done = 0, m_pass = 0, m_fail = 0;
    bit m_p6 = 0;
    int m_pairs = 0;
    logic [AW-1:0] m_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(rd_req_o === m_busy, "R3 rd_req_o", 32'(rd_req_o), 32'(m_busy));
        chk(rd_addr_o === m_addr, "R2 rd_addr_o", 32'(rd_addr_o), 32'(m_addr));
        chk(done_o === m_done, "R8 done_o", 32'(done_o), 32'(m_done));
        chk(pass_o === m_pass, "R4 pass_o", 32'(pass_o), 32'(m_pass));
        chk(fail_o === m_fail, "R7 fail_o", 32'(fail_o), 32'(m_fail));
    endtask

    task automatic step(input bit st, input logic [AW-1:0] pa);
        bit dn;
        logic [DW-1:0] d;
        @(negedge clk);
        compare_all();
        dn = 0;
        d = '0;
        if (m_busy) begin
            if (lat_cnt >= lat) begin
                dn = 1;
                d = (rq.size() > 0) ? rq.pop_front() : '0;
                lat_cnt = 0;
            end else lat_cnt++;
        end else lat_cnt = 0;
        start_i = st;
        poll_addr_i = pa;
        rd_done_i = dn;
        rd_data_i = d;
        m_done = 0; m_pass = 0; m_fail = 0;
        if (!m_busy) begin
            if (st) begin
                m_busy = 1; m_addr = pa; m_first = 1; m_rc = 0; m_pairs = 0;
            end
        end else if (dn) begin
            if (m_first) begin
                m_p6 = d[6]; m_first = 0;
            end else begin
                m_first = 1;
                if (d[6] == m_p6) begin
                    m_busy = 0; m_done = 1; m_pass = 1;
                end else if (m_rc) begin
                    m_busy = 0; m_done = 1; m_fail = 1;
                end else if (d[5]) begin
                    m_rc = 1;
                end else begin
                    m_pairs++;
                    if (m_pairs == MAXP) begin
                        m_busy = 0; m_done = 1; m_fail = 1;
                    end
                end
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [AW-1:0] pa, input int l,
                            input bit exp_pass, input int busy_start_at);
        int n = 0;
        bit seen = 0, got_pass = 0, got_fail = 0;
        lat = l;
        step(1, pa);
        while (!seen && n < 2000) begin
            n++;
            if (n == busy_start_at) step(1, pa ^ 24'h00FF00);
            else step(0, pa);
            @(posedge clk);
            #1;
            if (done_o) begin
                seen = 1; got_pass = pass_o; got_fail = fail_o;
            end
        end
        if (!seen) chk(0, {tag, " watchdog"}, 0, 1);
        else begin
            chk(got_pass == exp_pass && got_fail == !exp_pass, tag,
                32'({got_pass, got_fail}), 32'({exp_pass, !exp_pass}));
        end
        step(0, '0);
        step(0, '0);
        rq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(!rd_req_o && !done_o && !pass_o && !fail_o && rd_addr_o == '0, "R1 in reset",
            32'({rd_req_o, done_o, pass_o, fail_o}), 0);
        rst = 1'b0;
        step(0, '0);
        step(0, '0);

        // R4: settled at the first pair
        rq.push_back(16'h0040); rq.push_back(16'h0040);
        run_case("R4 settled pair", 24'h001234, 2, 1, 0);

        // R5: two toggling pairs with bit 5 clear, then settled
        rq.push_back(16'h0040); rq.push_back(16'h0000);
        rq.push_back(16'h0040); rq.push_back(16'h0000);
        rq.push_back(16'h0000); rq.push_back(16'h0000);
        run_case("R5 repeat pairs", 24'h0ABCDE, 0, 1, 0);

        // R5: bit 5 only in the earlier read does not trigger a recheck
        rq.push_back(16'h0060); rq.push_back(16'h0000);
        rq.push_back(16'h0060); rq.push_back(16'h0000);
        rq.push_back(16'h0040); rq.push_back(16'h0040);
        run_case("R5 earlier bit5 ignored", 24'h000010, 1, 1, 0);

        // R6: timeout flagged but recheck pair settled
        rq.push_back(16'h0040); rq.push_back(16'h0020);
        rq.push_back(16'h0020); rq.push_back(16'h0020);
        run_case("R6 recheck pass", 24'h3F0000, 3, 1, 0);

        // R7: recheck pair still toggles, bit 5 low
        rq.push_back(16'h0040); rq.push_back(16'h0020);
        rq.push_back(16'h0040); rq.push_back(16'h0000);
        run_case("R7 recheck fail", 24'h00003F, 1, 0, 0);

        // R7: recheck pair toggles with bit 5 high
        rq.push_back(16'h0000); rq.push_back(16'h0060);
        rq.push_back(16'h0020); rq.push_back(16'h0060);
        run_case("R7 recheck fail bit5", 24'h000040, 0, 0, 0);

        // R10: never settles, limit reached
        for (int i = 0; i < MAXP; i++) begin
            rq.push_back(16'h0040); rq.push_back(16'h0000);
        end
        run_case("R10 limit fail", 24'h555555, 0, 0, 0);

        // R10: settles on the last allowed pair boundary
        for (int i = 0; i < MAXP - 1; i++) begin
            rq.push_back(16'h0040); rq.push_back(16'h0000);
        end
        rq.push_back(16'h0040); rq.push_back(16'h0040);
        run_case("R10 settle at limit", 24'h000777, 0, 1, 0);

        // R9: start while busy changes nothing
        rq.push_back(16'h0040); rq.push_back(16'h0000);
        rq.push_back(16'h0040); rq.push_back(16'h0040);
        run_case("R9 busy start ignored", 24'h00AA00, 2, 1, 3);
        chk(rd_req_o === 1'b0, "R9 idle after busy start", 32'(rd_req_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule